// File: doc/BRIEF.md
# Clock-Crossing Register Access Bridge

This block lets a processor with a memory-mapped slave port in its own clock domain reach a bank of registers clocked by an unrelated user clock. The processor side sees a waitrequest-style slave port. The register side sees a plain strobe interface. A write is a one-cycle enable with address, data and byte enables. A read is a one-cycle request answered by a valid pulse after any number of cycles.

Only one access is in flight at any time. The processor-side front end captures the command, the address, the data and the byte enables into registers and flips a request toggle. A two-flop synchronizer carries that toggle into the user domain. There the back end issues the write strobe or the read request. Once the write is issued, or once the read data has been captured, the back end flips an acknowledge toggle, which returns through a second synchronizer. Waitrequest stays high for the whole exchange. It drops for exactly one processor cycle when the acknowledge arrives, and read data with its valid flag is presented in that same cycle.

Top module: `cdc_reg_bridge`

## Requirements
- R1: While either reset is held, av_waitrequest is 1, av_readdatavalid is 0, reg_wr_en is 0 and reg_rd_req is 0.
- R2: Each accepted processor write produces exactly one single-cycle reg_wr_en pulse. During that pulse, reg_addr, reg_wr_data and reg_wr_be equal the values that were presented with the write.
- R3: Byte enable bit k qualifies data bits [8k+7:8k]. A write with only some enable bits set changes only those bytes of the target register.
- R4: Each accepted processor read produces exactly one single-cycle reg_rd_req pulse. reg_addr stays unchanged from that pulse until reg_rd_valid returns.
- R5: The data returned with reg_rd_valid appears on av_readdata with av_readdatavalid high for exactly one cycle. That cycle is the one in which av_waitrequest is low. Writes never raise av_readdatavalid.
- R6: av_waitrequest stays high from acceptance until completion. It goes low for exactly one processor cycle per completed access.
- R7: Reads complete correctly for any register-side latency, from one cycle to tens of cycles.
- R8: reg_wr_en and reg_rd_req are never high in the same cycle.
- R9: Accesses complete in issue order. A read issued right after a write to the same address returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side clock |
| cpu_rst_n | input | 1 | Processor-side asynchronous reset, active low |
| av_address | input | ADDR_W | Dword address of the access |
| av_write | input | 1 | Write command |
| av_read | input | 1 | Read command |
| av_writedata | input | DATA_W | Write data |
| av_byteenable | input | DATA_W/8 | Byte enables for the write |
| av_waitrequest | output | 1 | Stall; low for one cycle when the access completes |
| av_readdata | output | DATA_W | Returned read data |
| av_readdatavalid | output | 1 | Read data valid |
| usr_clk | input | 1 | Register-side clock |
| usr_rst_n | input | 1 | Register-side asynchronous reset, active low |
| reg_addr | output | ADDR_W | Register address, shared by reads and writes |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DATA_W | Register write data |
| reg_wr_be | output | DATA_W/8 | Register write byte enables |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_data | input | DATA_W | Read data from the register bank |
| reg_rd_valid | input | 1 | Read data valid from the register bank |

## Verification
A lost or repeated request toggle shows up at the register side as a missing or doubled strobe, within a few user clocks of acceptance. A stuck acknowledge shows up at the processor side as a waitrequest that never drops. A wrong captured data path shows up as a read-back mismatch on the next read of that register. Reads are run with register-side latencies from short to long, so that any change of the shared address while a read is pending is exposed. A write followed at once by a read to the same register exposes any reordering or early completion.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_BUSY = 2'd1,
        C_DONE = 2'd2
    } cpu_st_e;

    typedef enum logic {
        U_IDLE   = 1'b0,
        U_RDWAIT = 1'b1
    } usr_st_e;
endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic tgl_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], tgl_i};
    end

    assign tgl_o = sh_q[STAGES-1];
endmodule

// File: rtl/bridge_cpu_side.sv
module bridge_cpu_side
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] av_address,
    input  logic              av_write,
    input  logic              av_read,
    input  logic [DATA_W-1:0] av_writedata,
    input  logic [BE_W-1:0]   av_byteenable,
    output logic              av_waitrequest,
    output logic [DATA_W-1:0] av_readdata,
    output logic              av_readdatavalid,
    input  logic              ack_tgl_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              req_tgl_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [BE_W-1:0]   be_o,
    output logic              is_rd_o
);
    typedef struct packed {
        cpu_st_e           cst;
        logic              req_tgl;
        logic              ack_seen;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic              is_rd;
        logic [DATA_W-1:0] rdata;
    } cpu_state_t;

    cpu_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.cst)
            C_IDLE: begin
                if (av_write || av_read) begin
                    s_d.addr    = av_address;
                    s_d.wdata   = av_writedata;
                    s_d.be      = av_byteenable;
                    s_d.is_rd   = !av_write;
                    s_d.req_tgl = !s_q.req_tgl;
                    s_d.cst     = C_BUSY;
                end
            end
            C_BUSY: begin
                if (ack_tgl_i != s_q.ack_seen) begin
                    s_d.ack_seen = ack_tgl_i;
                    s_d.rdata    = rdata_i;
                    s_d.cst      = C_DONE;
                end
            end
            default: s_d.cst = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cst: C_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign av_waitrequest   = (s_q.cst != C_DONE);
    assign av_readdatavalid = (s_q.cst == C_DONE) && s_q.is_rd;
    assign av_readdata      = s_q.rdata;
    assign req_tgl_o        = s_q.req_tgl;
    assign addr_o           = s_q.addr;
    assign wdata_o          = s_q.wdata;
    assign be_o             = s_q.be;
    assign is_rd_o          = s_q.is_rd;

    // R6: the stall is released for a single cycle only
    a_r6_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        !av_waitrequest |=> av_waitrequest);

    // R5: valid read data appears only in the release cycle
    a_r5_rdv_in_release: assert property (@(posedge clk) disable iff (!rst_n)
        av_readdatavalid |-> !av_waitrequest);

    // R9: captured command stays put while the exchange is pending
    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cst == C_BUSY) |=> $stable(req_tgl_o) && $stable(addr_o) && $stable(is_rd_o));
endmodule

// File: rtl/bridge_usr_side.sv
module bridge_usr_side
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl_i,
    input  logic              is_rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              reg_rd_valid,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_wr_en,
    output logic              reg_rd_req,
    output logic              ack_tgl_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        usr_st_e           ust;
        logic              req_seen;
        logic              ack_tgl;
        logic              wr_en;
        logic              rd_req;
        logic [DATA_W-1:0] rdata;
    } usr_state_t;

    usr_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.wr_en  = 1'b0;
        s_d.rd_req = 1'b0;
        case (s_q.ust)
            U_IDLE: begin
                if (req_tgl_i != s_q.req_seen) begin
                    s_d.req_seen = req_tgl_i;
                    if (is_rd_i) begin
                        s_d.rd_req = 1'b1;
                        s_d.ust    = U_RDWAIT;
                    end else begin
                        s_d.wr_en   = 1'b1;
                        s_d.ack_tgl = !s_q.ack_tgl;
                    end
                end
            end
            default: begin
                if (reg_rd_valid) begin
                    s_d.rdata   = reg_rd_data;
                    s_d.ack_tgl = !s_q.ack_tgl;
                    s_d.ust     = U_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ust: U_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign reg_wr_en  = s_q.wr_en;
    assign reg_rd_req = s_q.rd_req;
    assign ack_tgl_o  = s_q.ack_tgl;
    assign rdata_o    = s_q.rdata;

    // R8: write strobe and read request are exclusive
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_req));

    // R2: write strobe lasts one cycle
    a_r2_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R4: read request lasts one cycle
    a_r4_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_req |=> !reg_rd_req);

    // R4: shared address is steady while a read is outstanding
    a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ust == U_RDWAIT) |=> $stable(addr_i));
endmodule

// File: rtl/cdc_reg_bridge.sv
module cdc_reg_bridge #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int BE_W       = DATA_W / 8
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic [ADDR_W-1:0] av_address,
    input  logic              av_write,
    input  logic              av_read,
    input  logic [DATA_W-1:0] av_writedata,
    input  logic [BE_W-1:0]   av_byteenable,
    output logic              av_waitrequest,
    output logic [DATA_W-1:0] av_readdata,
    output logic              av_readdatavalid,
    input  logic              usr_clk,
    input  logic              usr_rst_n,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [BE_W-1:0]   reg_wr_be,
    output logic              reg_rd_req,
    input  logic [DATA_W-1:0] reg_rd_data,
    input  logic              reg_rd_valid
);
    logic              req_tgl, req_tgl_usr;
    logic              ack_tgl, ack_tgl_cpu;
    logic              is_rd;
    logic [DATA_W-1:0] rdata_hold;

    bridge_cpu_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cpu (
        .clk              (cpu_clk),
        .rst_n            (cpu_rst_n),
        .av_address       (av_address),
        .av_write         (av_write),
        .av_read          (av_read),
        .av_writedata     (av_writedata),
        .av_byteenable    (av_byteenable),
        .av_waitrequest   (av_waitrequest),
        .av_readdata      (av_readdata),
        .av_readdatavalid (av_readdatavalid),
        .ack_tgl_i        (ack_tgl_cpu),
        .rdata_i          (rdata_hold),
        .req_tgl_o        (req_tgl),
        .addr_o           (reg_addr),
        .wdata_o          (reg_wr_data),
        .be_o             (reg_wr_be),
        .is_rd_o          (is_rd)
    );

    tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (usr_clk),
        .rst_n (usr_rst_n),
        .tgl_i (req_tgl),
        .tgl_o (req_tgl_usr)
    );

    tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .tgl_i (ack_tgl),
        .tgl_o (ack_tgl_cpu)
    );

    bridge_usr_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_usr (
        .clk          (usr_clk),
        .rst_n        (usr_rst_n),
        .req_tgl_i    (req_tgl_usr),
        .is_rd_i      (is_rd),
        .addr_i       (reg_addr),
        .reg_rd_valid (reg_rd_valid),
        .reg_rd_data  (reg_rd_data),
        .reg_wr_en    (reg_wr_en),
        .reg_rd_req   (reg_rd_req),
        .ack_tgl_o    (ack_tgl),
        .rdata_o      (rdata_hold)
    );
endmodule

// File: tb/sim_cdc_reg_bridge.sv
module sim_cdc_reg_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int USR_PERIOD = 14;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          cpu_clk = 0, usr_clk = 0;
    logic          cpu_rst_n = 0, usr_rst_n = 0;
    logic [AW-1:0] av_address = '0;
    logic          av_write = 0, av_read = 0;
    logic [DW-1:0] av_writedata = '0;
    logic [3:0]    av_byteenable = '0;
    logic          av_waitrequest, av_readdatavalid;
    logic [DW-1:0] av_readdata;
    logic [AW-1:0] reg_addr;
    logic          reg_wr_en, reg_rd_req;
    logic [DW-1:0] reg_wr_data;
    logic [3:0]    reg_wr_be;
    logic [DW-1:0] reg_rd_data = '0;
    logic          reg_rd_valid = 0;

    int checks = 0, fails = 0, cycles = 0;
    int wr_pulses = 0, rd_pulses = 0, rdv_pulses = 0, both_hi = 0, addr_err = 0;
    int rd_lat = 1, cnt = 0;
    bit pend = 0;
    logic [AW-1:0] pend_addr, last_waddr;
    logic [DW-1:0] last_wdata;
    logic [3:0]    last_wbe;
    logic [DW-1:0] smem [16];
    logic [DW-1:0] exp_mem [16];

    always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
    always #(USR_PERIOD/2) usr_clk = ~usr_clk;

    cdc_reg_bridge u0 (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .av_address(av_address),
        .av_write(av_write), .av_read(av_read), .av_writedata(av_writedata),
        .av_byteenable(av_byteenable), .av_waitrequest(av_waitrequest),
        .av_readdata(av_readdata), .av_readdatavalid(av_readdatavalid),
        .usr_clk(usr_clk), .usr_rst_n(usr_rst_n), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be),
        .reg_rd_req(reg_rd_req), .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid)
    );

    // register bank model on the user side
    initial for (int i = 0; i < 16; i++) begin smem[i] = '0; exp_mem[i] = '0; end

    always @(posedge usr_clk) begin
        reg_rd_valid <= 1'b0;
        if (reg_wr_en && reg_rd_req) both_hi++;
        if (reg_wr_en) begin
            wr_pulses++;
            last_waddr = reg_addr; last_wdata = reg_wr_data; last_wbe = reg_wr_be;
            for (int b = 0; b < 4; b++)
                if (reg_wr_be[b]) smem[reg_addr[3:0]][8*b +: 8] <= reg_wr_data[8*b +: 8];
        end
        if (pend) begin
            if (reg_addr != pend_addr) addr_err++;
            if (cnt <= 1) begin
                reg_rd_valid <= 1'b1;
                reg_rd_data  <= smem[reg_addr[3:0]];
                pend <= 0;
            end else cnt <= cnt - 1;
        end
        if (reg_rd_req) begin
            rd_pulses++; pend <= 1; cnt <= rd_lat; pend_addr <= reg_addr;
        end
    end

    always @(posedge cpu_clk) begin
        cycles++;
        if (av_readdatavalid) rdv_pulses++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [3:0] be);
        logic [DW-1:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] be);
        int w0 = wr_pulses, v0 = rdv_pulses;
        @(negedge cpu_clk);
        av_address = a; av_writedata = d; av_byteenable = be; av_write = 1;
        do @(negedge cpu_clk); while (av_waitrequest);
        @(posedge cpu_clk); #1 av_write = 0;
        @(negedge cpu_clk);
        chk(av_waitrequest == 1, "R6 release lasts one cycle", av_waitrequest, 1);
        chk(wr_pulses == w0 + 1, "R2 one strobe per write", wr_pulses - w0, 1);
        chk(last_waddr == a && last_wdata == d && last_wbe == be, "R2 strobe fields",
            {last_waddr, last_wdata}, {a, d});
        chk(rdv_pulses == v0, "R5 no read valid on write", rdv_pulses - v0, 0);
        exp_mem[a[3:0]] = merge(exp_mem[a[3:0]], d, be);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input int lat, input string req);
        int r0 = rd_pulses, v0 = rdv_pulses, e0 = addr_err;
        logic [DW-1:0] got;
        logic gotv;
        rd_lat = lat;
        @(negedge cpu_clk);
        av_address = a; av_read = 1;
        do @(negedge cpu_clk); while (av_waitrequest);
        got = av_readdata; gotv = av_readdatavalid;
        @(posedge cpu_clk); #1 av_read = 0;
        @(negedge cpu_clk);
        chk(gotv == 1, "R5 valid with release", gotv, 1);
        chk(got == exp_mem[a[3:0]], req, got, exp_mem[a[3:0]]);
        chk(rdv_pulses == v0 + 1, "R5 single valid pulse", rdv_pulses - v0, 1);
        chk(rd_pulses == r0 + 1, "R4 one request per read", rd_pulses - r0, 1);
        chk(addr_err == e0, "R4 address steady", addr_err - e0, 0);
    endtask

    task automatic t_reset;
        @(negedge cpu_clk);
        chk(av_waitrequest == 1, "R1 waitrequest in reset", av_waitrequest, 1);
        chk(av_readdatavalid == 0, "R1 readdatavalid in reset", av_readdatavalid, 0);
        chk(reg_wr_en == 0, "R1 wr_en in reset", reg_wr_en, 0);
        chk(reg_rd_req == 0, "R1 rd_req in reset", reg_rd_req, 0);
    endtask

    task automatic t_full_words;
        bus_write(12'h003, 32'h1122_3344, 4'hF);
        bus_write(12'h00A, 32'hDEAD_BEEF, 4'hF);
        bus_read(12'h003, 1, "R2 full word readback");
        bus_read(12'h00A, 2, "R2 second word readback");
    endtask

    task automatic t_byte_enables;
        bus_write(12'h003, 32'hFFFF_FFFF, 4'b0101);
        bus_read(12'h003, 1, "R3 bytes 0 and 2 only");
        bus_write(12'h00A, 32'h0000_0000, 4'b1000);
        bus_read(12'h00A, 1, "R3 top byte only");
        bus_write(12'h005, 32'hA5A5_A5A5, 4'b0000);
        bus_read(12'h005, 1, "R3 no enables no change");
    endtask

    task automatic t_latency;
        bus_write(12'h007, 32'h0BAD_F00D, 4'hF);
        bus_read(12'h007, 1, "R7 latency 1");
        bus_read(12'h007, 5, "R7 latency 5");
        bus_read(12'h007, 40, "R7 latency 40");
    endtask

    task automatic t_ordering;
        bus_write(12'h00C, 32'h1357_9BDF, 4'hF);
        bus_read(12'h00C, 3, "R9 read after write");
        bus_write(12'h00C, 32'h2468_ACE0, 4'b0011);
        bus_read(12'h00C, 1, "R9 read after partial write");
        chk(both_hi == 0, "R8 strobes exclusive", both_hi, 0);
    endtask

    initial begin
        repeat (3) @(posedge cpu_clk);
        t_reset;
        #3 cpu_rst_n = 1; usr_rst_n = 1;
        repeat (4) @(posedge usr_clk);
        t_full_words;
        t_byte_enables;
        t_latency;
        t_ordering;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule